// File: doc/BRIEF.md
# Prescaled PWM with Deferred Control

This block is a single-channel pulse-width modulator. A binary divider chain makes a counting tick at one of sixteen power-of-two rates. An 8-bit period counter advances on that tick. The output pin is driven from a comparison between the counter and a programmed width value.

Software sets up the channel through a small synchronous register port. Address 0 holds a control byte and address 1 holds the width. While the channel runs, any change to control or width goes into a shadow copy. The shadow is applied only when the period counter wraps, so a cycle that is already under way is never cut short or stretched.

Clearing the enable bit is the exception and acts at once. The output then goes to a programmable idle level, and the counters are held at zero. Setting enable again starts a fresh period straight away with the latest settings.

Top module: `pwm_deferred`

## Requirements
- R1: After reset the control register reads 0x20, the width register reads 0, and the output is high (channel disabled, idle level 1).
- R2: The control byte holds enable at bit 7, force-high at bit 6, idle level at bit 5, a reserved bit at bit 4 and the clock-select code at bits 3:0. The reserved bit ignores writes and reads back 0. Address 0 selects control and address 1 selects width.
- R3: While enable is clear, the output equals the idle-level bit from the clock edge of the control write onward. The prescaler and the period counter hold at 0.
- R4: With clock-select code N, the period counter advances once every 2^N clocks, from every clock at code 0 to every 32768 clocks at code 15. It wraps from 255 to 0.
- R5: With enable set and force-high clear, the output is high while the period count is below the active width and low otherwise. A width of 0 gives a constant low output.
- R6: Control and width writes made while enabled go to a shadow copy and take effect only at the edge where the counter wraps. Reads return the shadow values.
- R7: Writing enable as 0 while running applies at once, in the middle of a period.
- R8: Writing enable as 1 while disabled applies the new control and the shadow width at once. The prescaler and period counter restart from 0.
- R9: Force-high with enable set drives the output high for the whole period. When it is set while running, it waits for the next wrap.
- R10: Force-high has no effect on the output while enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 control, 1 width |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected shadow register |
| pwm_out | output | 1 | PWM output pin |

## Verification
The hardest situation to reach from the ports is a write made in the middle of a running period. Here the old settings must stay in force for the rest of the period and the new ones must appear exactly at the wrap. The stimulus writes width, force-high and clock-select changes part-way through a period. It then samples the pin just before and just after the wrap edge, at points where the old and new settings predict different levels. A further sequence disables the channel in mid-period and enables it again, which shows that the counters restart from zero instead of resuming.

// File: rtl/pwm_pkg.sv
// Package: shared types and constants of the deferred-control PWM.
// Assumes an 8-bit control byte with the field layout given by R2.
package pwm_pkg;
    typedef struct packed {
        logic       en;
        logic       frc;
        logic       lvl;
        logic       rsv;
        logic [3:0] sel;
    } pwm_ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/pwm_prescaler.sv
// Prescaler: a free-running binary divider that emits one tick every
// 2^sel clocks while run is high. It is held at zero while run is low.
// Assumes sel < DIV_W + 1.
module pwm_prescaler #(
    parameter int DIV_W = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick,
    output logic [DIV_W-1:0] div_cnt
);
    logic [DIV_W-1:0] mask;

    // Build the low-bit mask whose bits are all set when a tick is due.
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    // Advance the divider while running, clear it while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end

    // Tick when every masked low bit of the divider is set.
    always_comb tick = run && ((div_cnt & mask) == mask);
endmodule

// File: rtl/pwm_period.sv
// Period counter: counts prescaler ticks and flags the tick on which it
// wraps from its maximum back to zero. It is held at zero while run is low.
module pwm_period #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Step the period count on each tick, clear it while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) count <= '0;
        else if (tick)      count <= count + 1'b1;
    end

    // Cycle boundary: a tick while the count is at its maximum.
    always_comb wrap = tick && (count == CNT_MAX);
endmodule

// File: rtl/pwm_regs.sv
// Register bank: shadow copies of control and width, written by software,
// and active copies that drive the channel. Active copies load from the
// shadow at a wrap. They load at once when the channel is disabled, or
// when the write disables it.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_addr,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    input  logic             wrap,
    output pwm_ctrl_t        ctrl_shadow,
    output pwm_ctrl_t        ctrl_active,
    output logic [CNT_W-1:0] width_shadow,
    output logic [CNT_W-1:0] width_active
);
    pwm_ctrl_t wr_ctrl;
    logic      ctrl_wr;
    logic      width_wr;
    logic      ctrl_now;

    // Decode the write and mask off the reserved bit.
    always_comb begin
        ctrl_wr      = reg_we && !reg_addr;
        width_wr     = reg_we && reg_addr;
        wr_ctrl      = pwm_ctrl_t'(reg_wdata);
        wr_ctrl.rsv  = 1'b0;
        ctrl_now     = ctrl_wr && (!wr_ctrl.en || !ctrl_active.en);
    end

    // Software-visible shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_shadow  <= pwm_ctrl_t'(CTRL_RESET);
            width_shadow <= '0;
        end else begin
            if (ctrl_wr)  ctrl_shadow  <= wr_ctrl;
            if (width_wr) width_shadow <= reg_wdata[CNT_W-1:0];
        end
    end

    // Active control: immediate on enable change from idle or on disable,
    // otherwise at the period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_active <= pwm_ctrl_t'(CTRL_RESET);
        else if (ctrl_now)                  ctrl_active <= wr_ctrl;
        else if (ctrl_active.en && wrap)    ctrl_active <= ctrl_shadow;
    end

    // Active width: tracks the shadow while idle, otherwise loads at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                  width_active <= '0;
        else if (!ctrl_active.en)    width_active <= width_wr ? reg_wdata[CNT_W-1:0] : width_shadow;
        else if (wrap)               width_active <= width_shadow;
    end
endmodule

// File: rtl/pwm_deferred.sv
// Top: a single-channel PWM with deferred control updates. It joins the
// register bank, the prescaler and the period counter, and forms the pin.
// Assumes CNT_W <= 8, so the width fits the 8-bit data bus.
module pwm_deferred
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 15,
    parameter int SEL_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       pwm_out
);
    pwm_ctrl_t        ctrl_shadow;
    pwm_ctrl_t        ctrl_active;
    logic [CNT_W-1:0] width_shadow;
    logic [CNT_W-1:0] width_active;
    logic [CNT_W-1:0] count;
    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    logic             wrap;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .wrap(wrap), .ctrl_shadow(ctrl_shadow),
        .ctrl_active(ctrl_active), .width_shadow(width_shadow),
        .width_active(width_active)
    );

    pwm_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl_active.en),
        .sel(ctrl_active.sel[SEL_W-1:0]), .tick(tick), .div_cnt(div_cnt)
    );

    pwm_period #(.CNT_W(CNT_W)) u_period (
        .clk(clk), .rst_n(rst_n), .run(ctrl_active.en), .tick(tick),
        .count(count), .wrap(wrap)
    );

    // Read mux over the shadow registers.
    always_comb reg_rdata = reg_addr ? 8'(width_shadow) : ctrl_shadow;

    // Pin: idle level when disabled, high under force, else compare.
    always_comb begin
        if (!ctrl_active.en)     pwm_out = ctrl_active.lvl;
        else if (ctrl_active.frc) pwm_out = 1'b1;
        else                     pwm_out = (count < width_active);
    end
endmodule

// File: rtl/pwm_deferred_chk.sv
// Checker: temporal properties of the deferred-control PWM, bound into
// the top module.
module pwm_deferred_chk #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_addr,
    input logic             reg_we,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             pwm_out,
    input logic [7:0]       ctrl_active,
    input logic [CNT_W-1:0] width_active,
    input logic [CNT_W-1:0] count,
    input logic [DIV_W-1:0] div_cnt,
    input logic             wrap
);
    // R2: reserved control bit always reads 0
    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> !reg_rdata[4]);

    // R3: divider is cleared one edge after the channel is stopped
    assert_presc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_active[7] |=> (div_cnt == '0));

    // R4: period count only steps by one or wraps to zero
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1) || count == '0));

    // R5: zero width in normal mode keeps the pin low
    assert_width0_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_active[7] && !ctrl_active[6] && width_active == '0) |-> !pwm_out);

    // R6: while running, active control changes only at a wrap
    assert_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_active[7] && $past(ctrl_active[7]) && ctrl_active != $past(ctrl_active))
        |-> $past(wrap));

    // R7: a disabling write shows its idle level on the next cycle
    assert_disable_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_addr && !reg_wdata[7]) |=> (pwm_out == $past(reg_wdata[5])));

    // R9: active force-high while running keeps the pin high
    assert_force_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_active[7] && ctrl_active[6]) |-> pwm_out);
endmodule

bind pwm_deferred pwm_deferred_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
    .ctrl_active(ctrl_active), .width_active(width_active),
    .count(count), .div_cnt(div_cnt), .wrap(wrap)
);

// File: tb/pwm_deferred_bench.sv
// Bench: a vector table walked by one loop, then directed tests.
module pwm_deferred_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pwm_out;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    pwm_deferred u_pwm_deferred (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    // Vector table: clock-select, width, edges after enable, expected pin.
    localparam int NV = 12;
    localparam int V_SEL [NV] = '{0, 0, 0, 2, 2, 3, 0, 0, 4, 4, 1, 1};
    localparam int V_WID [NV] = '{10, 10, 10, 3, 3, 0, 255, 255, 1, 1, 128, 128};
    localparam int V_K   [NV] = '{5, 10, 265, 11, 12, 0, 254, 255, 15, 16, 255, 256};
    localparam int V_EXP [NV] = '{1, 0, 1, 1, 0, 0, 1, 0, 1, 0, 1, 0};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write; called at a falling edge, returns at the next falling edge.
    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_edges(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_addr = 1'b0; #1;
        chk("R1 ctrl", reg_rdata, 8'h20);
        chk("R1 pin", {7'd0, pwm_out}, 8'd1);
        reg_addr = 1'b1; #1;
        chk("R1 width", reg_rdata, 8'h00);

        // R2: reserved bit dropped; idle level drives pin
        wr(1'b0, 8'h3F);
        reg_addr = 1'b0; #1;
        chk("R2 readback", reg_rdata, 8'h2F);
        chk("R2 idle pin", {7'd0, pwm_out}, 8'd1);
        // R10: force-high with enable clear has no effect
        wr(1'b0, 8'h40);
        chk("R10 pin", {7'd0, pwm_out}, 8'd0);
        // R3: idle level applies at once
        wr(1'b0, 8'h20);
        chk("R3 idle high", {7'd0, pwm_out}, 8'd1);
        wr(1'b0, 8'h00);
        chk("R3 idle low", {7'd0, pwm_out}, 8'd0);

        // R4 / R5: table of rates and widths
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, 8'h00);
            wr(1'b1, 8'(V_WID[i]));
            wr(1'b0, 8'h80 | 8'(V_SEL[i]));
            wait_edges(V_K[i]);
            chk($sformatf("R4/R5 vector %0d", i), {7'd0, pwm_out}, 8'(V_EXP[i]));
        end

        // R6: width change while running waits for wrap
        wr(1'b0, 8'h00);
        wr(1'b1, 8'd100);
        wr(1'b0, 8'h80);            // k=0
        wait_edges(49);             // k=49
        wr(1'b1, 8'd20);            // k=50
        reg_addr = 1'b1; #1;
        chk("R6 width shadow read", reg_rdata, 8'd20);
        chk("R6 old width k50", {7'd0, pwm_out}, 8'd1);
        wait_edges(40);             // k=90
        chk("R6 old width k90", {7'd0, pwm_out}, 8'd1);
        wait_edges(196);            // k=286, count 30
        chk("R6 new width after wrap", {7'd0, pwm_out}, 8'd0);
        // R9: force-high deferred, then whole period high
        wr(1'b0, 8'hC0);            // k=287
        chk("R9 deferred k287", {7'd0, pwm_out}, 8'd0);
        wait_edges(224);            // k=511
        chk("R9 deferred k511", {7'd0, pwm_out}, 8'd0);
        wait_edges(1);              // k=512
        chk("R9 applied at wrap", {7'd0, pwm_out}, 8'd1);
        wait_edges(88);             // k=600
        chk("R9 held high", {7'd0, pwm_out}, 8'd1);
        // R7: disable in mid-period acts at once
        wr(1'b0, 8'h00);
        chk("R7 disable now", {7'd0, pwm_out}, 8'd0);

        // R8: re-enable applies settings at once, counters restart
        wr(1'b1, 8'd5);
        wr(1'b0, 8'hA0);            // k=0
        chk("R8 start high", {7'd0, pwm_out}, 8'd1);
        wait_edges(5);
        chk("R8 low at count 5", {7'd0, pwm_out}, 8'd0);
        wait_edges(2);              // k=7
        wr(1'b0, 8'h20);
        chk("R7 idle high", {7'd0, pwm_out}, 8'd1);
        wr(1'b0, 8'h80);            // k=0 again
        chk("R8 counter restarted", {7'd0, pwm_out}, 8'd1);

        // R6 / R4: clock-select change while running waits for wrap
        wr(1'b0, 8'h00);
        wr(1'b1, 8'd12);
        wr(1'b0, 8'h80);            // k=0
        wait_edges(10);             // k=10
        wr(1'b0, 8'h82);            // k=11
        reg_addr = 1'b0; #1;
        chk("R6 ctrl shadow read", reg_rdata, 8'h82);
        chk("R6 k11", {7'd0, pwm_out}, 8'd1);
        wait_edges(1);              // k=12
        chk("R6 old rate k12", {7'd0, pwm_out}, 8'd0);
        wait_edges(285);            // k=297, count 10
        chk("R4 new rate k297", {7'd0, pwm_out}, 8'd1);
        wait_edges(7);              // k=304, count 12
        chk("R4 new rate k304", {7'd0, pwm_out}, 8'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule